// File: doc/BRIEF.md
# Two-Level High-Resolution PWM Generator

This block drives a single PWM pin from one fast clock, which serves as the high-resolution (HR) clock. Time is organised on two levels. A loop-resolution period (LRP) is a power-of-two number of HR clocks. The PWM period is a whole number of LRPs. The rising edge always falls on the HR cycle that opens a period. The falling edge is placed in two steps. A coarse compare selects the LRP in which the edge lands. A fine delay counter then moves the edge by a number of HR clocks past that LRP's first cycle. Duty resolution is therefore one HR clock, while the period stays a multiple of the LRP.

Software or a DMA engine writes the duty word through a one-cycle write strobe. The word goes into a shadow register. It is copied to the working register only at the close of a period, so a period never mixes two duty values. The LRP size select and the period length are sampled at the same point.

A build-time option selects the loop-resolution variant. In that variant the fine part is ignored and the falling edge sits exactly at the start of the chosen LRP.

Top module: `hrpwm_gen`

## Requirements
- R1: While `rst` is high, `pwm_out` is low, both position counters are zero and a zero duty is loaded. The first period after reset is therefore low no matter what is written during it.
- R2: An LRP lasts 2^(S+1) HR clocks, where S is `lrp_sel`. A value of S above MAX_SEL (default 6) is treated as MAX_SEL. S is sampled during reset and in the last HR cycle of each period, and applies from the next period on.
- R3: A period lasts P LRPs, where P is `period_lrp`. A value below 3 is treated as 3. P is sampled on the same cycles as S. Define the position k as the HR cycle index within a period. `pwm_out` during the cycle after position k shows the level for position k. The only rising edge is the one for k = 0.
- R4: A `duty_wr` pulse stores `duty_word` in a shadow register. The working duty takes the shadow value in the last HR cycle of each period. A write made in that same last cycle is the one that applies to the next period.
- R5: `duty_word` bits [18:7] hold the coarse count C, in LRPs. Bits [6:0] hold the fine delay F, in HR clocks. A value of F greater than L-1 (L is the LRP length) is treated as L-1. With 0 < C < P, the output is high exactly for the positions k < C*L + F.
- R6: A falling edge occurs only during LRP number C of the period.
- R7: C = 0 holds the output low for the whole period, whatever F is.
- R8: C >= P holds the output high for the whole period, with no falling edge.
- R9: With the loop-resolution variant (RES_MODE = RES_LOOP), F has no effect: the output is high exactly for k < C*L.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | HR clock; every register uses its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| lrp_sel | input | 3 | LRP size select S (LRP = 2^(S+1) HR clocks) |
| period_lrp | input | 12 | Period length P, counted in LRPs |
| duty_wr | input | 1 | One-cycle write strobe for `duty_word` |
| duty_word | input | 19 | Duty: coarse count C in [18:7], fine delay F in [6:0] |
| pwm_out | output | 1 | PWM pin, registered |

## Verification
The pin is registered, so the level for position k appears in the cycle after the counters stand at k. A duty write, or a change of S or P, shows up only from the next period start. The earliest possible effect is the cycle after the final position of the current period. The bench model steps the same position arithmetic at every rising edge, using the inputs as driven at the preceding falling edge. It then compares `pwm_out` at the following falling edge, so each expected level is checked in the exact cycle it is due. Writes aimed at the last cycle of a period are timed from the model's own position count.

// File: rtl/hrpwm_pkg.sv
package hrpwm_pkg;

   // Placement of the falling edge: LRP boundary only, or boundary plus HR delay
   typedef enum logic {
      RES_LOOP = 1'b0,
      RES_HIGH = 1'b1
   } res_mode_e;

   // HR clocks in one LRP for a given size select
   function automatic int unsigned lrp_cycles(input int unsigned sel);
      return 32'd2 << sel;
   endfunction

endpackage

// File: rtl/hrpwm_lrp_timer.sv
module hrpwm_lrp_timer #(
   parameter int unsigned SEL_W   = 3,
   parameter int unsigned MAX_SEL = 6,
   parameter int unsigned LRP_W   = 7
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [SEL_W-1:0] sel_in,
   input  logic             reload,
   output logic [LRP_W-1:0] lrp_cnt,
   output logic [LRP_W-1:0] lrp_len_m1,
   output logic             lrp_last
);

   localparam logic [SEL_W-1:0] SEL_CAP = SEL_W'(MAX_SEL);

   logic [SEL_W-1:0] sel_q;
   logic [SEL_W-1:0] sel_lim;

   assign sel_lim    = (sel_in > SEL_CAP) ? SEL_CAP : sel_in;
   assign lrp_len_m1 = LRP_W'((32'd2 << sel_q) - 32'd1);
   assign lrp_last   = (lrp_cnt == lrp_len_m1);

   // size select is taken only at reset and at a period boundary
   always_ff @(posedge clk) begin
      if (rst || reload) begin
         sel_q <= sel_lim;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         lrp_cnt <= '0;
      end else if (lrp_last) begin
         lrp_cnt <= '0;
      end else begin
         lrp_cnt <= lrp_cnt + 1'b1;
      end
   end

   // R2: the position inside an LRP never passes the LRP length
   a_r2_cnt_in_lrp : assert property (@(posedge clk) disable iff (rst)
      lrp_cnt <= lrp_len_m1);

   // R2: LRP length changes only right after a period boundary
   a_r2_len_hold : assert property (@(posedge clk) disable iff (rst)
      !$past(reload) |-> $stable(lrp_len_m1));

endmodule

// File: rtl/hrpwm_period_ctr.sv
module hrpwm_period_ctr #(
   parameter int unsigned PER_W   = 12,
   parameter int unsigned MIN_PER = 3
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [PER_W-1:0] per_in,
   input  logic             lrp_last,
   output logic [PER_W-1:0] per_idx,
   output logic             per_last
);

   localparam logic [PER_W-1:0] PER_FLOOR = PER_W'(MIN_PER);

   logic [PER_W-1:0] per_q;
   logic [PER_W-1:0] per_lim;
   logic             reload;

   assign per_lim  = (per_in < PER_FLOOR) ? PER_FLOOR : per_in;
   assign per_last = (per_idx == per_q - 1'b1);
   assign reload   = lrp_last && per_last;

   always_ff @(posedge clk) begin
      if (rst || reload) begin
         per_q <= per_lim;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         per_idx <= '0;
      end else if (lrp_last) begin
         per_idx <= per_last ? '0 : per_idx + 1'b1;
      end
   end

   // R3: the LRP index stays inside the latched period
   a_r3_idx_range : assert property (@(posedge clk) disable iff (rst)
      per_idx < per_q);

   // R3: the period length never drops under the floor
   a_r3_len_floor : assert property (@(posedge clk) disable iff (rst)
      per_q >= PER_FLOOR);

endmodule

// File: rtl/hrpwm_duty_regs.sv
module hrpwm_duty_regs #(
   parameter int unsigned PER_W  = 12,
   parameter int unsigned FINE_W = 7
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    wr,
   input  logic [PER_W+FINE_W-1:0] wr_word,
   input  logic                    period_end,
   output logic [PER_W-1:0]        coarse,
   output logic [FINE_W-1:0]       fine
);

   localparam int unsigned DUTY_W = PER_W + FINE_W;

   logic [DUTY_W-1:0] shadow_q;
   logic [DUTY_W-1:0] active_q;
   logic [DUTY_W-1:0] next_word;

   // a write landing in the final cycle bypasses the shadow
   assign next_word = wr ? wr_word : shadow_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         shadow_q <= '0;
      end else if (wr) begin
         shadow_q <= wr_word;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         active_q <= '0;
      end else if (period_end) begin
         active_q <= next_word;
      end
   end

   assign coarse = active_q[DUTY_W-1:FINE_W];
   assign fine   = active_q[FINE_W-1:0];

   // R4: the working duty moves only at a period boundary
   a_r4_active_hold : assert property (@(posedge clk) disable iff (rst)
      !$past(period_end) |-> $stable(active_q));

endmodule

// File: rtl/hrpwm_edge_sched.sv
module hrpwm_edge_sched
   import hrpwm_pkg::*;
#(
   parameter int unsigned PER_W    = 12,
   parameter int unsigned FINE_W   = 7,
   parameter int unsigned LRP_W    = 7,
   parameter res_mode_e   RES_MODE = RES_HIGH
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              pos0,
   input  logic [LRP_W-1:0]  lrp_cnt,
   input  logic [LRP_W-1:0]  lrp_len_m1,
   input  logic [PER_W-1:0]  per_idx,
   input  logic [PER_W-1:0]  coarse,
   input  logic [FINE_W-1:0] fine_in,
   output logic              pwm_out
);

   logic at_coarse;
   logic fall;

   // first HR cycle of the LRP chosen by the coarse count
   assign at_coarse = (coarse != '0) && (per_idx == coarse) && (lrp_cnt == '0);

   if (RES_MODE == RES_HIGH) begin : g_hires
      logic [FINE_W-1:0] len_ext;
      logic [FINE_W-1:0] fine_eff;
      logic [FINE_W-1:0] fine_cnt;
      logic              armed;

      assign len_ext  = FINE_W'(lrp_len_m1);
      assign fine_eff = (fine_in > len_ext) ? len_ext : fine_in;
      assign fall     = (at_coarse && (fine_eff == '0)) || (armed && (fine_cnt == '0));

      // per-pin delay counter, clocked by the HR clock
      always_ff @(posedge clk) begin
         if (rst) begin
            armed    <= 1'b0;
            fine_cnt <= '0;
         end else if (at_coarse) begin
            armed    <= (fine_eff != '0);
            fine_cnt <= (fine_eff != '0) ? fine_eff - 1'b1 : '0;
         end else if (armed) begin
            if (fine_cnt == '0) begin
               armed <= 1'b0;
            end else begin
               fine_cnt <= fine_cnt - 1'b1;
            end
         end
      end

      // R5: a pending delay always ends before the LRP does
      a_r5_fine_in_lrp : assert property (@(posedge clk) disable iff (rst)
         armed |-> (fine_cnt < len_ext));

      // R5: a pending delay only runs during the coarse LRP
      a_r5_armed_in_coarse : assert property (@(posedge clk) disable iff (rst)
         armed |-> (per_idx == coarse));
   end else begin : g_loop
      logic unused_fine;
      assign unused_fine = ^{fine_in, lrp_len_m1};
      assign fall        = at_coarse;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         pwm_out <= 1'b0;
      end else if (pos0) begin
         pwm_out <= (coarse != '0);
      end else if (fall) begin
         pwm_out <= 1'b0;
      end
   end

   // R3: the pin rises only for position zero of a period
   a_r3_rise_at_start : assert property (@(posedge clk) disable iff (rst)
      $rose(pwm_out) |-> $past(pos0));

   // R6: the pin falls only while inside the coarse LRP
   a_r6_fall_in_coarse : assert property (@(posedge clk) disable iff (rst)
      $fell(pwm_out) |-> $past(per_idx == coarse));

endmodule

// File: rtl/hrpwm_gen.sv
module hrpwm_gen
   import hrpwm_pkg::*;
#(
   parameter int unsigned SEL_W    = 3,
   parameter int unsigned MAX_SEL  = 6,
   parameter int unsigned PER_W    = 12,
   parameter int unsigned FINE_W   = 7,
   parameter int unsigned MIN_PER  = 3,
   parameter res_mode_e   RES_MODE = RES_HIGH
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic [SEL_W-1:0]        lrp_sel,
   input  logic [PER_W-1:0]        period_lrp,
   input  logic                    duty_wr,
   input  logic [PER_W+FINE_W-1:0] duty_word,
   output logic                    pwm_out
);

   localparam int unsigned MAX_LRP = lrp_cycles(MAX_SEL);
   localparam int unsigned LRP_W   = $clog2(MAX_LRP);

   // build-time parameter checks
   if (MAX_LRP > (32'd1 << FINE_W)) begin : g_bad_fine
      $error("fine delay field too narrow for the largest LRP");
   end
   if (MAX_SEL >= (32'd1 << SEL_W)) begin : g_bad_sel
      $error("MAX_SEL cannot be coded in the select width");
   end
   if (MIN_PER < 3) begin : g_bad_per
      $error("a period needs more than two LRPs");
   end
   if (PER_W < 2) begin : g_bad_perw
      $error("period width too small for the minimum period");
   end

   logic [LRP_W-1:0]  lrp_cnt;
   logic [LRP_W-1:0]  lrp_len_m1;
   logic              lrp_last;
   logic [PER_W-1:0]  per_idx;
   logic              per_last;
   logic              period_end;
   logic              pos0;
   logic [PER_W-1:0]  coarse;
   logic [FINE_W-1:0] fine;

   assign period_end = lrp_last && per_last;
   assign pos0       = (lrp_cnt == '0) && (per_idx == '0);

   hrpwm_lrp_timer #(
      .SEL_W   (SEL_W),
      .MAX_SEL (MAX_SEL),
      .LRP_W   (LRP_W)
   ) u_timer (
      .clk        (clk),
      .rst        (rst),
      .sel_in     (lrp_sel),
      .reload     (period_end),
      .lrp_cnt    (lrp_cnt),
      .lrp_len_m1 (lrp_len_m1),
      .lrp_last   (lrp_last)
   );

   hrpwm_period_ctr #(
      .PER_W   (PER_W),
      .MIN_PER (MIN_PER)
   ) u_period (
      .clk      (clk),
      .rst      (rst),
      .per_in   (period_lrp),
      .lrp_last (lrp_last),
      .per_idx  (per_idx),
      .per_last (per_last)
   );

   hrpwm_duty_regs #(
      .PER_W  (PER_W),
      .FINE_W (FINE_W)
   ) u_duty (
      .clk        (clk),
      .rst        (rst),
      .wr         (duty_wr),
      .wr_word    (duty_word),
      .period_end (period_end),
      .coarse     (coarse),
      .fine       (fine)
   );

   hrpwm_edge_sched #(
      .PER_W    (PER_W),
      .FINE_W   (FINE_W),
      .LRP_W    (LRP_W),
      .RES_MODE (RES_MODE)
   ) u_sched (
      .clk        (clk),
      .rst        (rst),
      .pos0       (pos0),
      .lrp_cnt    (lrp_cnt),
      .lrp_len_m1 (lrp_len_m1),
      .per_idx    (per_idx),
      .coarse     (coarse),
      .fine_in    (fine),
      .pwm_out    (pwm_out)
   );

   // R1: reset forces the pin low on the next cycle
   a_r1_reset_low : assert property (@(posedge clk)
      rst |=> !pwm_out);

endmodule

// File: tb/hrpwm_gen_tb_top.sv
module hrpwm_gen_tb_top;
   import hrpwm_pkg::*;

   localparam time CLK_PERIOD = 10ns;
   localparam int  WATCHDOG   = 150000;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [2:0]  lrp_sel = 3'd0;
   logic [11:0] period_lrp = 12'd5;
   logic        duty_wr = 1'b0;
   logic [18:0] duty_word = '0;
   logic        out_hr;
   logic        out_lr;

   int          compared = 0;
   int          mismatched = 0;
   string       cur_req = "R1";
   bit          done = 1'b0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   hrpwm_gen dut_i (
      .clk (clk), .rst (rst), .lrp_sel (lrp_sel), .period_lrp (period_lrp),
      .duty_wr (duty_wr), .duty_word (duty_word), .pwm_out (out_hr)
   );

   hrpwm_gen #(.RES_MODE(RES_LOOP)) dut_lr_i (
      .clk (clk), .rst (rst), .lrp_sel (lrp_sel), .period_lrp (period_lrp),
      .duty_wr (duty_wr), .duty_word (duty_word), .pwm_out (out_lr)
   );

   // behavioural reference: index 0 high-resolution, index 1 loop-resolution
   int m_k[2], m_L[2], m_P[2], m_C[2], m_F[2], m_sh[2];
   bit m_out[2];

   function automatic int len_of(input int sel);
      return 2 << ((sel > 6) ? 6 : sel);
   endfunction

   function automatic int per_of(input int p);
      return (p < 3) ? 3 : p;
   endfunction

   always @(posedge clk) begin
      for (int i = 0; i < 2; i++) begin
         if (rst) begin
            m_k[i] = 0; m_L[i] = len_of(int'(lrp_sel)); m_P[i] = per_of(int'(period_lrp));
            m_C[i] = 0; m_F[i] = 0; m_sh[i] = 0; m_out[i] = 1'b0;
         end else begin
            int feff;
            int nw;
            feff = (i == 0) ? ((m_F[i] > m_L[i] - 1) ? m_L[i] - 1 : m_F[i]) : 0;
            m_out[i] = (m_C[i] != 0) && ((m_C[i] >= m_P[i]) || (m_k[i] < m_C[i] * m_L[i] + feff));
            nw = duty_wr ? int'(duty_word) : m_sh[i];
            if (duty_wr) m_sh[i] = int'(duty_word);
            if (m_k[i] == m_P[i] * m_L[i] - 1) begin
               m_C[i] = nw >> 7; m_F[i] = nw & 127;
               m_L[i] = len_of(int'(lrp_sel)); m_P[i] = per_of(int'(period_lrp));
               m_k[i] = 0;
            end else begin
               m_k[i] = m_k[i] + 1;
            end
         end
      end
   end

   // compare both pins against the model away from the active edge
   always @(negedge clk) begin
      if (!done) begin
         compared += 2;
         if (out_hr !== m_out[0]) begin
            mismatched++;
            $display("FAIL %s hr pin: actual %b expected %b (pos %0d)", cur_req, out_hr, m_out[0], m_k[0]);
         end
         if (out_lr !== m_out[1]) begin
            mismatched++;
            $display("FAIL R9 lr pin: actual %b expected %b (pos %0d)", out_lr, m_out[1], m_k[1]);
         end
      end
   end

   task automatic write_duty(input int c, input int f);
      @(negedge clk);
      duty_wr   = 1'b1;
      duty_word = {12'(c), 7'(f)};
      @(negedge clk);
      duty_wr   = 1'b0;
   endtask

   task automatic wait_pos(input int target);
      do @(negedge clk); while (m_k[0] != target);
   endtask

   task automatic periods(input int n);
      for (int j = 0; j < n; j++) wait_pos(0);
   endtask

   initial begin : watchdog
      repeat (WATCHDOG) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         mismatched++;
         $display("FAIL watchdog: actual timeout expected finish");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end

   initial begin : stimulus
      // R1: reset state and a write during the first period left unused
      cur_req = "R1";
      repeat (5) @(negedge clk);
      rst = 1'b0;
      write_duty(2, 1);
      periods(1);
      // R2 R3: smallest LRP, five-LRP period
      cur_req = "R3";
      periods(3);
      // R5: LRP of 8, sweep of fine delays including an over-range value
      cur_req = "R5";
      lrp_sel = 3'd2; period_lrp = 12'd6;
      for (int f = 0; f < 9; f++) begin
         write_duty(3, f);
         periods(2);
      end
      write_duty(1, 20);
      periods(2);
      // R6: falling edge late in the period
      cur_req = "R6";
      write_duty(5, 7);
      periods(2);
      // R7: zero coarse ignores fine
      cur_req = "R7";
      write_duty(0, 5);
      periods(2);
      // R8: coarse at and above the period
      cur_req = "R8";
      write_duty(6, 0);
      periods(2);
      write_duty(4095, 127);
      periods(2);
      // R4: write mid-period, then a write in the last cycle of a period
      cur_req = "R4";
      write_duty(2, 3);
      wait_pos(20);
      write_duty(4, 2);
      periods(2);
      wait_pos(6 * 8 - 1);
      duty_wr = 1'b1; duty_word = {12'd1, 7'd6};
      @(negedge clk);
      duty_wr = 1'b0;
      periods(2);
      // R3: period below the floor
      cur_req = "R3";
      period_lrp = 12'd1;
      write_duty(2, 5);
      periods(3);
      // R2: select above the cap gives the largest LRP
      cur_req = "R2";
      lrp_sel = 3'd7; period_lrp = 12'd3;
      write_duty(1, 100);
      periods(3);
      // R9: loop-resolution pin on a mid-range duty
      cur_req = "R9";
      lrp_sel = 3'd1; period_lrp = 12'd7;
      write_duty(3, 2);
      periods(3);
      // R1: reset in mid-period clears everything
      cur_req = "R1";
      wait_pos(5);
      rst = 1'b1;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      periods(2);
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

endmodule